// File: doc/BRIEF.md
# Serial-Programmed DAC Code Receiver

This block is the digital front end of a small voltage-output converter. It listens on a two-wire I2C-compatible bus as a write-only target and runs entirely from a fast system clock. Both bus lines are synchronised and filtered, so spikes shorter than a set number of system clocks are rejected. From the filtered lines the block detects start, stop and repeated-start conditions. It answers one of four bus addresses, chosen by a two-bit strap. The last bit of the address byte does not select a read or a write. It is taken as a power-down request.

A complete transfer has a start, the address byte, one data byte and a stop. The block acknowledges the address byte and, when no power-down is requested, the data byte as well. Only the stop that closes such a transfer copies the eight data bits into the code register and the power-down request into the shutdown flag. A transfer that stops early, or one where a repeated start replaces the stop, leaves both registers unchanged. The analog converter that follows reads `code_o` and `shdn_o`. The block's only drive onto the bus is `sda_low_o`, which enables the pad's open-drain pull-down.

Top module: `dls_dac_slave`

## Requirements
- R1: After reset, `code_o` is 0x00, `shdn_o` is 0 and `sda_low_o` is 0.
- R2: The block answers only the 7-bit address 0x30 + `addr_sel`. Sent left-justified, the first byte is 0x60, 0x62, 0x64 or 0x66 with bit 0 clear. A first byte with any other upper seven bits gets no acknowledge, and the rest of that transfer changes nothing.
- R3: When the address matches, SDA is pulled low from the falling SCL edge after the eighth bit until the falling edge after the ninth, so the master reads 0 on the ninth clock. The drive never changes while SCL is high.
- R4: The data byte is shifted in MSB first. At the closing stop all 8 bits, the six code bits followed by the two sub-bits, appear unchanged on `code_o[7:0]`.
- R5: Bit 0 of the address byte is the power-down request, where 1 means shut down. It reaches `shdn_o` at the same stop that updates `code_o`.
- R6: An address byte followed at once by a stop or a repeated start is acknowledged for either value of bit 0 and changes neither output.
- R7: A repeated start after the data byte, in place of the stop, drops the pending update.
- R8: When bit 0 of the address byte is 1, the data byte is not acknowledged and SDA stays released on its ninth clock. The code and the shutdown flag still update at the following stop.
- R9: The general-call byte 0x00 and 10-bit address prefixes (upper five bits 11110) are not acknowledged and change nothing.
- R10: An SCL pulse shorter than `FILT_LEN` system clocks is ignored, and the transfer around it completes correctly.
- R11: A start in the middle of a byte restarts address reception. A stop in the middle of a transfer leaves both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap that picks one of the four addresses |
| code_o | output | 8 | Committed converter code (6 bits + 2 sub-bits) |
| shdn_o | output | 1 | Committed power-down state, 1 = shut down |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench builds the block with `FILT_LEN` = 4 and holds each quarter of a bus bit for 12 system clocks. Every legal edge therefore clears the filter with a wide margin. The injected SCL spike lasts 3 clocks, one less than the acceptance threshold, which tests the filter right at its edge. The 7-bit address space is small, so the random mix of matching and arbitrary first bytes reaches every strap setting and both values of the power-down bit. The directed cases add the general-call byte and a 10-bit prefix, mid-byte aborts and a repeated start after the data byte.

// File: rtl/dls_pkg.sv
// Package: shared types and constants for the serial DAC code receiver.
// Assumes: nothing beyond standard SystemVerilog.
package dls_pkg;

    // Bus address base; the 2-bit strap is added to it.
    localparam logic [6:0] BASE_ADDR = 7'h30;

    // Frame sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a start
        ST_ADDR,     // shifting the address byte
        ST_AACK_W,   // address matched, waiting for SCL low
        ST_AACK_D,   // driving the address acknowledge
        ST_DATA,     // shifting the data byte
        ST_DACK_W,   // data byte complete, waiting for SCL low
        ST_DACK_D,   // ninth clock of the data byte
        ST_HOLD      // update pending, waiting for stop
    } dls_state_t;

endpackage

// File: rtl/dls_glitch_filter.sv
// Module: one input lane made of a two-flop synchroniser and a stability counter.
// Does: the filtered output follows the synchronised input only after that
//       input has differed from it for STABLE_CLKS consecutive clocks.
// Assumes: STABLE_CLKS >= 1; RST_VAL is the idle level of the line.
module dls_glitch_filter #(
    parameter int   STABLE_CLKS = 4,
    parameter logic RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE_CLKS + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          out_q;

    // Bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {RST_VAL, RST_VAL};
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a new level only once it has been stable long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= RST_VAL;
        end else if (sync_q[1] == out_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE_CLKS - 1)) begin
            cnt_q <= '0;
            out_q <= sync_q[1];
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/dls_bus_cond.sv
// Module: bus condition detector on the filtered lines.
// Does: flags SCL rising and falling edges, and start (SDA falls while SCL
//       is high) and stop (SDA rises while SCL is high), each for one clock.
// Assumes: both inputs pass through filters of equal delay.
module dls_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    // Hold the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // Decode edges and bus conditions.
    always_comb begin
        scl_rise  = scl_f & ~scl_d;
        scl_fall  = ~scl_f & scl_d;
        start_det = scl_f & scl_d & sda_d & ~sda_f;
        stop_det  = scl_f & scl_d & ~sda_d & sda_f;
    end
endmodule

// File: rtl/dls_frame_fsm.sv
// Module: frame sequencer for the two-byte write.
// Does: shifts in the address and data bytes on SCL rising edges, decides the
//       acknowledges, and raises commit for one clock when a stop closes a
//       complete transfer.
// Assumes: a start or stop pulse has priority over any edge in the same clock.
module dls_frame_fsm
    import dls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_f,
    input  logic [6:0] my_addr,
    output logic       sda_low,
    output logic       commit,
    output logic [7:0] new_code,
    output logic       new_shdn
);
    dls_state_t state_q;
    logic [7:0] shreg_q;
    logic [2:0] bitcnt_q;
    logic       shdn_req_q;

    // Sequence the frame: bus conditions first, then the per-state edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            bitcnt_q   <= '0;
            shdn_req_q <= 1'b0;
        end else if (start_det) begin
            state_q  <= ST_ADDR;
            bitcnt_q <= '0;
        end else if (stop_det) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_ADDR: if (scl_rise) begin
                    shreg_q  <= {shreg_q[6:0], sda_f};
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == 3'd7) begin
                        if (shreg_q[6:0] == my_addr) begin
                            state_q    <= ST_AACK_W;
                            shdn_req_q <= sda_f;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_AACK_W: if (scl_fall) state_q <= ST_AACK_D;
                ST_AACK_D: if (scl_fall) begin
                    state_q  <= ST_DATA;
                    bitcnt_q <= '0;
                end
                ST_DATA: if (scl_rise) begin
                    shreg_q  <= {shreg_q[6:0], sda_f};
                    bitcnt_q <= bitcnt_q + 1'b1;
                    if (bitcnt_q == 3'd7) state_q <= ST_DACK_W;
                end
                ST_DACK_W: if (scl_fall) state_q <= ST_DACK_D;
                ST_DACK_D: if (scl_fall) state_q <= ST_HOLD;
                default: ;
            endcase
        end
    end

    // Drive the acknowledge and present the pending update.
    always_comb begin
        sda_low  = (state_q == ST_AACK_D) ||
                   ((state_q == ST_DACK_D) && !shdn_req_q);
        commit   = stop_det && (state_q == ST_HOLD);
        new_code = shreg_q;
        new_shdn = shdn_req_q;
    end
endmodule

// File: rtl/dls_dac_slave.sv
// Module: top of the serial DAC code receiver.
// Does: filters both bus lines, detects bus conditions, sequences the frame
//       and holds the committed code and shutdown registers.
// Assumes: clk runs at least 8 * FILT_LEN times faster than SCL.
module dls_dac_slave #(
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_sel,
    output logic [7:0] code_o,
    output logic       shdn_o,
    output logic       sda_low_o
);
    localparam int LANES = 2;

    logic [LANES-1:0] pad_w, filt_w;
    logic scl_rise_w, scl_fall_w, start_w, stop_w;
    logic commit_w, new_shdn_w;
    logic [7:0] new_code_w;
    logic [6:0] my_addr_w;
    logic [7:0] code_q;
    logic       shdn_q;

    assign pad_w     = {sda_i, scl_i};
    assign my_addr_w = dls_pkg::BASE_ADDR + {5'd0, addr_sel};

    // One filter lane per bus line.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dls_glitch_filter #(.STABLE_CLKS(FILT_LEN), .RST_VAL(1'b1)) i_filt (
            .clk (clk),
            .rst_n (rst_n),
            .din (pad_w[g]),
            .dout (filt_w[g])
        );
    end

    dls_bus_cond i_cond (
        .clk (clk),
        .rst_n (rst_n),
        .scl_f (filt_w[0]),
        .sda_f (filt_w[1]),
        .scl_rise (scl_rise_w),
        .scl_fall (scl_fall_w),
        .start_det (start_w),
        .stop_det (stop_w)
    );

    dls_frame_fsm i_fsm (
        .clk (clk),
        .rst_n (rst_n),
        .scl_rise (scl_rise_w),
        .scl_fall (scl_fall_w),
        .start_det (start_w),
        .stop_det (stop_w),
        .sda_f (filt_w[1]),
        .my_addr (my_addr_w),
        .sda_low (sda_low_o),
        .commit (commit_w),
        .new_code (new_code_w),
        .new_shdn (new_shdn_w)
    );

    // Committed outputs change only on a closing stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            shdn_q <= 1'b0;
        end else if (commit_w) begin
            code_q <= new_code_w;
            shdn_q <= new_shdn_w;
        end
    end

    assign code_o = code_q;
    assign shdn_o = shdn_q;
endmodule

// File: rtl/dls_dac_slave_chk.sv
// Module: protocol checker for dls_dac_slave, attached with bind.
// Does: checks that committed outputs move only after a stop and that the
//       SDA drive moves only while SCL is low.
// Assumes: reset is asserted from time zero.
module dls_dac_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] code_o,
    input logic       shdn_o,
    input logic       sda_low_o,
    input logic       scl_f,
    input logic       scl_fall,
    input logic       stop_det
);
    // R4: the code register moves only in the clock after a stop.
    p_code_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> $past(stop_det));

    // R5: the shutdown flag moves only in the clock after a stop.
    p_shdn_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(shdn_o) |-> $past(stop_det));

    // R3: the acknowledge drive starts only after a falling SCL edge.
    p_ack_after_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> $past(scl_fall));

    // R3: the drive holds steady while filtered SCL stays high.
    p_sda_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_low_o));

    // R3: the drive is released in the clock after a falling SCL edge that ends the ninth clock.
    p_release_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_low_o) |-> $past(scl_fall));
endmodule

bind dls_dac_slave dls_dac_slave_chk i_chk (
    .clk (clk),
    .rst_n (rst_n),
    .code_o (code_o),
    .shdn_o (shdn_o),
    .sda_low_o (sda_low_o),
    .scl_f (filt_w[0]),
    .scl_fall (scl_fall_w),
    .stop_det (stop_w)
);

// File: tb/test_dls_dac_slave.sv
// Bench: drives bus transfers as a master and checks acks and committed state.
module test_dls_dac_slave;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 4;
    localparam int Q = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic [7:0] code_o;
    logic shdn_o, sda_low_o;
    wire bus_sda = m_sda & ~sda_low_o;

    int checks = 0, errors = 0;
    logic [7:0] exp_code = 8'h00;
    logic exp_shdn = 1'b0;

    dls_dac_slave #(.FILT_LEN(FILT)) i_dls_dac_slave (
        .clk (clk), .rst_n (rst_n), .scl_i (m_scl), .sda_i (bus_sda),
        .addr_sel (addr_sel), .code_o (code_o), .shdn_o (shdn_o),
        .sda_low_o (sda_low_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_addr_ack(input logic [7:0] b, input logic [1:0] sel);
        return b[7:1] == (7'h30 + {5'd0, sel});
    endfunction

    task automatic bus_start;
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(2*Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i];
            if (glitch && i == 4) begin
                wt(Q/2);
                m_scl = 1'b1; wt(FILT - 1);
                m_scl = 1'b0; wt(Q/2);
            end else begin
                wt(Q);
            end
            m_scl = 1'b1; wt(2*Q);
            m_scl = 1'b0; wt(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        ack = ~bus_sda;
        wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic check_state(input string tag);
        wt(4*Q);
        chk(code_o == exp_code, tag, code_o, exp_code);
        chk(shdn_o == exp_shdn, tag, shdn_o, exp_shdn);
        chk(sda_low_o == 1'b0, {tag, " bus released"}, sda_low_o, 0);
    endtask

    // Full write; mode 0 = stop, 1 = address-only probe, 2 = restart in place of stop.
    task automatic xfer(input logic [7:0] ab, input logic [7:0] db, input int mode,
                        input bit glitch, input string tag);
        bit a_ack, d_ack, ea;
        ea = exp_addr_ack(ab, addr_sel);
        bus_start;
        send_byte(ab, 1'b0, a_ack);
        chk(a_ack == ea, {tag, " R2/R3 address ack"}, a_ack, ea);
        if (ea && mode != 1) begin
            send_byte(db, glitch, d_ack);
            chk(d_ack == !ab[0], {tag, " R8 data ack"}, d_ack, !ab[0]);
            if (mode == 2) bus_start;
            else begin exp_code = db; exp_shdn = ab[0]; end
        end else if (ea && mode == 1 && db[0]) begin
            bus_start;
        end
        bus_stop;
        check_state(tag);
    endtask

    initial begin
        void'($urandom(32'h1234_5eed));
        wt(5);
        chk(code_o == 8'h00, "R1 code", code_o, 0);
        chk(shdn_o == 1'b0, "R1 shdn", shdn_o, 0);
        chk(sda_low_o == 1'b0, "R1 sda", sda_low_o, 0);
        rst_n = 1'b1;
        wt(5);

        xfer(8'h60, 8'hA5, 0, 0, "R4 basic write");
        xfer(8'h61, 8'h3C, 0, 0, "R5 R8 shutdown write");
        xfer(8'h60, 8'h81, 0, 0, "R5 wake write");
        addr_sel = 2'd1; wt(4);
        xfer(8'h63, 8'h00, 1, 0, "R6 probe shdn1");
        xfer(8'h62, 8'h01, 1, 0, "R6 probe restart");
        xfer(8'h62, 8'h5A, 2, 0, "R7 restart discards");
        xfer(8'h60, 8'h77, 0, 0, "R2 wrong address");
        xfer(8'h00, 8'h11, 0, 0, "R9 general call");
        xfer(8'hF0, 8'h22, 0, 0, "R9 ten-bit prefix");
        xfer(8'h62, 8'hC3, 0, 1, "R10 scl spike");

        begin : r11_abort
            bit a;
            bus_start;
            send_byte(8'h62, 1'b0, a);
            send_bits(8'hFF, 3, 1'b0);
            bus_stop;
            check_state("R11 stop mid-byte");
            bus_start;
            send_bits(8'h62, 5, 1'b0);
            xfer(8'h62, 8'h3E, 0, 0, "R11 start mid-byte");
        end

        for (int n = 0; n < 50; n++) begin
            logic [7:0] ab, db;
            int mode;
            addr_sel = 2'($urandom % 4);
            wt(4);
            ab = ($urandom % 4 != 0) ? {7'h30 + {5'd0, addr_sel}, 1'($urandom)} : 8'($urandom);
            db = 8'($urandom);
            mode = $urandom % 4;
            xfer(ab, db, (mode == 3) ? 0 : mode, 0, "R4 R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule